// File: doc/BRIEF.md
# Supply and Bus-Start Reset Supervisor

This block drives the reset output of a two-wire serial peripheral. It holds reset active while power comes up, and it releases reset only after a supply-good flag has stayed asserted for a set number of timebase ticks. If that flag drops later, reset asserts at once and stays asserted until the power-up delay has run again. A signal that blocks the bus follows the reset output, so the serial engine aborts any transfer in progress and accepts no new commands while reset is active. A separate nonvolatile-write-busy flag passes through without change, so a write that has already started can finish.

A watchdog runs alongside the supply checks. It counts timebase ticks since the last bus START, which is a falling SDA while SCL is high, seen on synchronized copies of the lines. A 2-bit select picks one of three periods or turns the watchdog off. When no START arrives within the selected period, the block raises reset for the same tick count that power-up uses. The watchdog ignores START conditions while reset is active, and it counts again from zero once reset is released.

A single-cycle tick-enable sets the timebase. A real chip feeds it a slow strobe, and a simulation can feed it every clock.

Top module: `supply_wdog_supervisor`

## Requirements
- R1: While `arst_n` is low, `rst_out` and `bus_block` read 1.
- R2: With `supply_ok` high continuously, `rst_out` falls at the clock edge that samples the RST_TICKS-th `tick`. Edges without `tick` do not count.
- R3: When `supply_ok` is 0, `rst_out` is 1 in the same cycle, with no clock edge needed. Once `supply_ok` returns, the full RST_TICKS delay runs again.
- R4: `wd_sel` encoding: 2'b01 selects WD_SHORT ticks, 2'b00 selects WD_MID and 2'b10 selects WD_LONG. With no START, `rst_out` rises on the tick edge that ends the selected period after the last reload. A reload happens when reset is released or when a START is accepted.
- R5: `wd_sel` = 2'b11 turns the watchdog off. No expiry happens, and the counter sits at zero. When the watchdog is enabled again, the full period runs from the moment it is enabled.
- R6: A START is an SDA falling edge with SCL high, seen after the input synchronizers. An accepted START reloads the counter SYNC_STAGES+1 edges after SDA falls at the pin.
- R7: An SDA fall or rise while SCL is low is not a START and does not reload the watchdog.
- R8: A watchdog expiry holds `rst_out` at 1 for RST_TICKS ticks, the same count that power-up uses.
- R9: A START while `rst_out` is 1 has no effect. The reset length is unchanged, and the watchdog counts its full period from the release.
- R10: `bus_block` equals `rst_out` at all times, whatever the cause of the reset.
- R11: `nvw_keep` follows `nvw_busy` whether or not reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous clear of the supervisor's own flops, active low |
| tick | input | 1 | Single-cycle timebase enable |
| supply_ok | input | 1 | Supply-good flag, already synchronized to clk |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| wd_sel | input | 2 | Watchdog period select (01 short, 00 mid, 10 long, 11 off) |
| nvw_busy | input | 1 | Nonvolatile write in progress |
| rst_out | output | 1 | Reset, active high |
| bus_block | output | 1 | Gates the serial interface while reset is active |
| nvw_keep | output | 1 | Write-busy flag, unaffected by reset |

## Verification
The assertions assume that `supply_ok`, `tick` and `wd_sel` are synchronous to `clk` and change only just after an edge. A supply glitch shorter than one cycle could otherwise make `rst_out` fall without a tick. They also assume that `tick` is a clean enable.

The stimulus keeps within these assumptions. It drives every input 1 ns after the rising edge, and it changes `wd_sel` only while reset is held or while the watchdog is off. It holds each SDA level for at least four edges, so the synchronizers settle. Random kick gaps are drawn from a range that stays at least two ticks short of expiry, so every sequence that is meant to be refreshed cannot time out.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef enum logic [1:0] {
      WDS_MID   = 2'b00,
      WDS_SHORT = 2'b01,
      WDS_LONG  = 2'b10,
      WDS_OFF   = 2'b11
   } wd_sel_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int          W      = 2,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '1
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= {STAGES{INIT}};
      else         stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_start_det.sv
module sup_start_det (
   input  logic clk,
   input  logic arst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   // SDA goes high -> low while SCL stays high across both samples
   assign start = scl_p & scl_s & sda_p & ~sda_s;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
   import sup_pkg::*;
#(
   parameter int T_SHORT = 250,
   parameter int T_MID   = 750,
   parameter int T_LONG  = 1400,
   localparam int CW     = $clog2(T_LONG + 1)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          tick,
   input  logic          hold,
   input  logic          kick,
   input  logic [1:0]    sel,
   output logic          expire,
   output logic [CW-1:0] elapsed
);
   logic [CW-1:0] last_cnt;
   logic          off;

   assign off = (wd_sel_e'(sel) == WDS_OFF);

   always_comb begin
      unique case (wd_sel_e'(sel))
         WDS_SHORT: last_cnt = CW'(T_SHORT - 1);
         WDS_MID:   last_cnt = CW'(T_MID - 1);
         WDS_LONG:  last_cnt = CW'(T_LONG - 1);
         default:   last_cnt = '0;
      endcase
   end

   assign expire = tick & ~hold & ~off & ~kick & (elapsed == last_cnt);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                    elapsed <= '0;
      else if (hold || off || kick)   elapsed <= '0;
      else if (expire)                elapsed <= '0;
      else if (tick)                  elapsed <= elapsed + 1'b1;
   end
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq #(
   parameter int RST_TICKS = 250,
   localparam int RW       = $clog2(RST_TICKS + 1)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   input  logic supply_ok,
   input  logic expire,
   output logic hold
);
   logic [RW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hold <= 1'b1;
         cnt  <= '0;
      end else if (!supply_ok) begin
         hold <= 1'b1;
         cnt  <= '0;
      end else if (hold) begin
         if (tick) begin
            if (cnt == RW'(RST_TICKS - 1)) begin
               hold <= 1'b0;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end else if (expire) begin
         hold <= 1'b1;
         cnt  <= '0;
      end
   end
endmodule

// File: rtl/supply_wdog_supervisor.sv
module supply_wdog_supervisor #(
   parameter int SYNC_STAGES = 2,
   parameter int RST_TICKS   = 250,
   parameter int WD_SHORT    = 250,
   parameter int WD_MID      = 750,
   parameter int WD_LONG     = 1400
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       tick,
   input  logic       supply_ok,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic [1:0] wd_sel,
   input  logic       nvw_busy,
   output logic       rst_out,
   output logic       bus_block,
   output logic       nvw_keep
);
   localparam int CW = $clog2(WD_LONG + 1);

   generate
      if (RST_TICKS < 2) begin : g_bad_rst
         $error("supply_wdog_supervisor: RST_TICKS must be at least 2");
      end
      if (!(WD_SHORT >= 8 && WD_SHORT < WD_MID && WD_MID < WD_LONG)) begin : g_bad_wd
         $error("supply_wdog_supervisor: need 8 <= WD_SHORT < WD_MID < WD_LONG");
      end
   endgenerate

   logic [1:0]    bus_s;
   logic          start, kick, expire, hold;
   logic [CW-1:0] wd_elapsed;

   sup_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
      .clk(clk), .arst_n(arst_n), .d({scl_in, sda_in}), .q(bus_s)
   );

   sup_start_det u_start (
      .clk(clk), .arst_n(arst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .start(start)
   );

   // bus activity is ignored for the whole reset period
   assign kick = start & ~rst_out;

   sup_wdog #(.T_SHORT(WD_SHORT), .T_MID(WD_MID), .T_LONG(WD_LONG)) u_wdog (
      .clk(clk), .arst_n(arst_n), .tick(tick), .hold(rst_out), .kick(kick),
      .sel(wd_sel), .expire(expire), .elapsed(wd_elapsed)
   );

   sup_rst_seq #(.RST_TICKS(RST_TICKS)) u_seq (
      .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
      .expire(expire), .hold(hold)
   );

   // a supply drop reaches the output without waiting for an edge
   assign rst_out   = hold | ~supply_ok;
   assign bus_block = rst_out;
   assign nvw_keep  = nvw_busy;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
   parameter int CW = 11
) (
   input logic          clk,
   input logic          arst_n,
   input logic          tick,
   input logic          supply_ok,
   input logic [1:0]    wd_sel,
   input logic          rst_out,
   input logic          bus_block,
   input logic [CW-1:0] wd_elapsed
);
   assert_low_supply_R3: assert property (@(posedge clk) disable iff (!arst_n)
      !supply_ok |-> (rst_out && bus_block));

   assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_out) |-> ($past(tick) && $past(supply_ok)));

   assert_off_idle_R5: assert property (@(posedge clk) disable iff (!arst_n)
      (wd_sel == 2'b11 && $past(wd_sel) == 2'b11) |-> (wd_elapsed == '0));

   assert_reset_clears_wd_R9: assert property (@(posedge clk) disable iff (!arst_n)
      rst_out |=> (wd_elapsed == '0));

   assert_expire_only_enabled_R4: assert property (@(posedge clk) disable iff (!arst_n)
      ($rose(rst_out) && $past(supply_ok) && supply_ok) |-> ($past(wd_sel) != 2'b11));
endmodule

bind supply_wdog_supervisor sup_checker #(.CW(CW)) u_chk (
   .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
   .wd_sel(wd_sel), .rst_out(rst_out), .bus_block(bus_block),
   .wd_elapsed(wd_elapsed)
);

// File: tb/sim_supply_wdog_supervisor.sv
`timescale 1ns/1ps
module sim_supply_wdog_supervisor;
   localparam int SYNC  = 2;
   localparam int RSTT  = 20;
   localparam int WS    = 30;
   localparam int WM    = 60;
   localparam int WL    = 90;
   localparam int KLEFT = 8 - (SYNC + 1);   // edges after reload inside a kick

   logic clk = 1'b0;
   logic arst_n, tick, supply_ok, scl, sda, nvw_busy;
   logic [1:0] wd_sel;
   logic rst_out, bus_block, nvw_keep;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   supply_wdog_supervisor #(
      .SYNC_STAGES(SYNC), .RST_TICKS(RSTT),
      .WD_SHORT(WS), .WD_MID(WM), .WD_LONG(WL)
   ) u0 (
      .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
      .scl_in(scl), .sda_in(sda), .wd_sel(wd_sel), .nvw_busy(nvw_busy),
      .rst_out(rst_out), .bus_block(bus_block), .nvw_keep(nvw_keep)
   );

   function automatic int period_of(input logic [1:0] s);
      case (s)
         2'b01:   return WS;
         2'b00:   return WM;
         2'b10:   return WL;
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk); #1;
   endtask

   task automatic count_until(input logic val, output int n);
      n = 0;
      while (rst_out !== val && n < 5000) begin
         edge1();
         n++;
      end
   endtask

   // START on the bus, then STOP; SDA is held each way for four edges
   task automatic kick(input bit chk_low, input string tag);
      sda = 1'b0;
      for (int i = 0; i < 4; i++) begin
         edge1();
         if (chk_low) check(rst_out == 1'b0, tag, rst_out, 0);
      end
      sda = 1'b1;
      for (int i = 0; i < 4; i++) begin
         edge1();
         if (chk_low) check(rst_out == 1'b0, tag, rst_out, 0);
      end
   endtask

   initial begin
      int n;
      void'($urandom(32'd5151));
      arst_n = 1'b0; tick = 1'b1; supply_ok = 1'b0; scl = 1'b1; sda = 1'b1;
      nvw_busy = 1'b0; wd_sel = 2'b01;
      repeat (3) edge1();
      check(rst_out == 1'b1, "R1 rst_out in clear", rst_out, 1);
      check(bus_block == 1'b1, "R1 R10 bus_block in clear", bus_block, 1);
      nvw_busy = 1'b1; #1;
      check(nvw_keep == 1'b1, "R11 nvw_keep during reset", nvw_keep, 1);
      nvw_busy = 1'b0; #1;
      check(nvw_keep == 1'b0, "R11 nvw_keep low", nvw_keep, 0);
      arst_n = 1'b1;
      edge1();

      // power-up delay
      supply_ok = 1'b1;
      count_until(1'b0, n);
      check(n == RSTT, "R2 power-up delay", n, RSTT);
      check(bus_block == 1'b0, "R10 bus_block released", bus_block, 0);

      // brown-out while running
      repeat (5) edge1();
      supply_ok = 1'b0; #1;
      check(rst_out == 1'b1, "R3 immediate reset", rst_out, 1);
      check(bus_block == 1'b1, "R10 bus_block on brown-out", bus_block, 1);
      repeat (4) edge1();
      check(rst_out == 1'b1, "R3 held while low", rst_out, 1);
      supply_ok = 1'b1;
      count_until(1'b0, n);
      check(n == RSTT, "R3 delay after recovery", n, RSTT);

      // short period expiry
      count_until(1'b1, n);
      check(n == WS, "R4 short period", n, WS);

      // kick during reset is ignored, mid period next
      wd_sel = 2'b00;
      kick(1'b0, "R9");
      count_until(1'b0, n);
      check(n == RSTT - 8, "R8 R9 reset length with kick", n, RSTT - 8);
      count_until(1'b1, n);
      check(n == WM, "R4 R9 mid period", n, WM);

      // slow timebase during the hold, long period after
      wd_sel = 2'b10;
      begin
         int ticks = 0;
         while (rst_out !== 1'b0 && ticks < 5000) begin
            tick = ~tick;
            @(posedge clk);
            if (tick) ticks++;
            #1;
         end
         check(ticks == RSTT, "R2 counts only ticks", ticks, RSTT);
      end
      tick = 1'b1;
      count_until(1'b1, n);
      check(n == WL, "R4 long period", n, WL);

      // SDA activity with SCL low is not a START
      wd_sel = 2'b01;
      count_until(1'b0, n);
      check(n == RSTT, "R8 watchdog reset length", n, RSTT);
      scl = 1'b0; repeat (4) edge1();
      sda = 1'b0; repeat (4) edge1();
      sda = 1'b1; repeat (4) edge1();
      scl = 1'b1;
      count_until(1'b1, n);
      check(n == WS - 12, "R7 no reload on SCL low", n, WS - 12);

      // watchdog off
      wd_sel = 2'b11;
      count_until(1'b0, n);
      begin
         int hits = 0;
         for (int i = 0; i < 200; i++) begin
            edge1();
            if (rst_out) hits++;
         end
         check(hits == 0, "R5 no expiry when off", hits, 0);
      end
      wd_sel = 2'b01;
      count_until(1'b1, n);
      check(n == WS, "R5 full period after enable", n, WS);

      // random kick trains
      for (int it = 0; it < 8; it++) begin
         logic [1:0] s;
         int L, nk;
         s  = 2'($urandom_range(0, 2));
         wd_sel = s;
         L  = period_of(s);
         count_until(1'b0, n);
         check(n == RSTT, "R8 reset length", n, RSTT);
         nk = $urandom_range(1, 4);
         for (int k = 0; k < nk; k++) begin
            if (k > 0) repeat ($urandom_range(0, L - 10)) edge1();
            kick(1'b1, "R6 refreshed watchdog stays quiet");
         end
         count_until(1'b1, n);
         check(n == L - KLEFT, "R6 expiry after last START", n, L - KLEFT);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule